// File: doc/BRIEF.md
# Page-Protected EEPROM Write Controller

This block sits in front of a 4096-byte nonvolatile array split into 128 pages of 32 bytes and decides which writes may reach it. Requests arrive on a one-beat command interface carrying an operation code, a 12-bit address, a data byte and a last-beat flag. A single byte can be written or read directly. A page write is a sequence of load beats gathered in a page buffer and committed together on the beat marked last.

Each page carries one write-permission bit. Software reads and clears it through protect requests that travel the same path as data writes. Once a page is locked it stays locked until reset. Every write, protect writes included, is also refused while the low-supply input is high. Each accepted write starts a programming interval. The busy output is high for that interval and every request made during it is refused. A refused request raises a one-cycle error pulse and changes nothing.

Top module: `pgprot_eewr`

## Requirements
- R1: After reset, busy, err and rd_valid are 0, and a protect read of any page returns 0x80, meaning the page is writable.
- R2: Address bits [11:5] give the page and bits [4:0] the byte within it. A read (op 0) accepted at a clock edge shows rd_valid=1 with the stored byte in the following cycle, and err stays 0. A byte write (op 1) to a writable page stores the byte.
- R3: Page-load beats (op 2) are handled as follows.
  - The first beat sets the page and the starting offset from its address.
  - Each later beat ignores its address and uses the next offset, which wraps from 31 to 0 inside the same page.
  - The beat with req_last=1 commits every loaded byte at once.
  - Bytes at offsets that were not loaded keep their old value.
- R4: A protect read (op 3) returns the page's bit on data bit 7, with bits 6:0 equal to 0. A protect write (op 4) takes the new bit from data bit 7, where 0 locks the page. Both ignore address bits [4:0]. Writing 1 to a writable page leaves it writable.
- R5: A protect write to a page whose bit is already 0 is refused with an err pulse, and the bit stays 0.
- R6: A byte write or page commit aimed at a locked page is refused with an err pulse, and the array is unchanged.
- R7: While low_supply is 1, byte writes, page commits and protect writes are refused with an err pulse and change nothing. Reads are still served.
- R8: An accepted write holds busy high for exactly PROG_CYCLES cycles, starting the cycle after acceptance. Any request arriving while busy is high is refused with an err pulse and has no effect.
- R9: While a page load is open, any request other than a load beat is refused with an err pulse, and the load carries on.
- R10: Operation codes 5 to 7 are refused with an err pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | 0 read, 1 byte write, 2 page-load beat, 3 protect read, 4 protect write |
| req_addr | input | 12 | Page in [11:5], byte offset in [4:0] |
| req_data | input | 8 | Write data; bit 7 carries the protect value |
| req_last | input | 1 | Marks the committing beat of a page load |
| low_supply | input | 1 | Supply too low for writing |
| busy | output | 1 | Programming interval in progress |
| err | output | 1 | One-cycle pulse for a refused request |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read result |

## Verification
The bench keeps the full default geometry of 128 pages of 32 bytes, so offset wrap across a real 32-byte page and protect reads of the top page are both exercised. It shortens PROG_CYCLES to 4. With that setting the busy window can be counted cycle by cycle, and refused requests inside the window, alongside locked-page and low-supply refusals, fit into a short run.

// File: rtl/pgprot_eewr.sv
module pgprot_eewr #(
  parameter int PAGES       = 128,
  parameter int PAGE_BYTES  = 32,
  parameter int DW          = 8,
  parameter int PROG_CYCLES = 20,
  localparam int PG_W  = $clog2(PAGES),
  localparam int OFS_W = $clog2(PAGE_BYTES),
  localparam int AW    = PG_W + OFS_W,
  localparam int DEPTH = PAGES * PAGE_BYTES,
  localparam int CW    = $clog2(PROG_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          req_last,
  input  logic          low_supply,
  output logic          busy,
  output logic          err,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0]         mem  [DEPTH];
  logic [DW-1:0]         pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pmask;
  logic [PAGES-1:0]      prot;
  logic                  pg_active;
  logic [PG_W-1:0]       pg_page;
  logic [OFS_W-1:0]      pg_ofs;
  logic [CW-1:0]         cnt;

  wire [PG_W-1:0]  a_pg  = req_addr[AW-1:OFS_W];
  wire [OFS_W-1:0] a_ofs = req_addr[OFS_W-1:0];
  wire [PG_W-1:0]  b_pg  = pg_active ? pg_page : a_pg;
  wire [OFS_W-1:0] b_ofs = pg_active ? pg_ofs  : a_ofs;

  assign busy = (cnt != '0);

  wire go      = req_valid && !busy;
  wire idle_ok = go && !pg_active;
  wire acc_rd  = idle_ok && (req_op == 3'd0 || req_op == 3'd3);
  wire acc_wr  = idle_ok && req_op == 3'd1 && !low_supply && prot[a_pg];
  wire acc_pwr = idle_ok && req_op == 3'd4 && !low_supply && prot[a_pg];
  wire acc_bt  = go && req_op == 3'd2;
  wire commit  = acc_bt && req_last && !low_supply && prot[b_pg];
  wire refuse  = req_valid && !(acc_rd || acc_wr || acc_pwr || (acc_bt && (!req_last || commit)));
  wire start   = acc_wr || acc_pwr || commit;

  always_ff @(posedge clk) begin
    if (acc_wr) mem[req_addr] <= req_data;
    if (commit)
      for (int i = 0; i < PAGE_BYTES; i++)
        if (pmask[i] || b_ofs == OFS_W'(i))
          mem[{b_pg, OFS_W'(i)}] <= (b_ofs == OFS_W'(i)) ? req_data : pbuf[i];
    if (acc_bt && !req_last) pbuf[b_ofs] <= req_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      prot      <= '1;
      pg_active <= 1'b0;
      pg_page   <= '0;
      pg_ofs    <= '0;
      pmask     <= '0;
      err       <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      err      <= refuse;
      rd_valid <= acc_rd;
      if (acc_rd)
        rd_data <= (req_op == 3'd0) ? mem[req_addr] : {prot[a_pg], {(DW-1){1'b0}}};
      if (acc_pwr && !req_data[DW-1]) prot[a_pg] <= 1'b0;
      if (start)     cnt <= CW'(PROG_CYCLES);
      else if (busy) cnt <= cnt - 1'b1;
      if (acc_bt) begin
        if (req_last) begin
          pg_active <= 1'b0;
          pmask     <= '0;
        end else begin
          pg_active     <= 1'b1;
          pg_page       <= b_pg;
          pg_ofs        <= b_ofs + 1'b1;
          pmask[b_ofs]  <= 1'b1;
        end
      end
    end
  end

endmodule

module pgprot_eewr_chk #(
  parameter int PAGES = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [2:0]       req_op,
  input logic             low_supply,
  input logic             busy,
  input logic             err,
  input logic             rd_valid,
  input logic             pg_active,
  input logic [PAGES-1:0] prot
);

  a_r8_busy_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && busy |=> err && !rd_valid);

  a_r8_busy_keeps_prot: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> prot == $past(prot));

  a_r5_prot_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (prot & ~$past(prot)) == '0);

  a_r7_low_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && low_supply && (req_op == 3'd1 || req_op == 3'd4) |=> err && !busy);

  a_r2_read_served: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy && !pg_active && req_op == 3'd0 |=> rd_valid && !err);

  a_r9_load_refuses_other: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && pg_active && req_op != 3'd2 |=> err);

  a_r10_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op > 3'd4 |=> err && !rd_valid);

endmodule

bind pgprot_eewr pgprot_eewr_chk #(.PAGES(PAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .low_supply(low_supply), .busy(busy), .err(err), .rd_valid(rd_valid),
  .pg_active(pg_active), .prot(prot)
);

// File: tb/sim_pgprot_eewr.sv
`timescale 1ns/1ps
module sim_pgprot_eewr;
  localparam int P = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_last = 0, low_supply = 0;
  logic [2:0] req_op = 0;
  logic [11:0] req_addr = 0;
  logic [7:0] req_data = 0;
  logic busy, err, rd_valid;
  logic [7:0] rd_data;

  int total = 0, bad = 0;

  always #2 clk = ~clk;

  pgprot_eewr #(.PROG_CYCLES(P)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .req_last(req_last),
    .low_supply(low_supply), .busy(busy), .err(err), .rd_valid(rd_valid),
    .rd_data(rd_data));

  typedef struct { bit e; bit v; logic [7:0] d; string tag; } exp_t;
  exp_t q[$];

  logic took = 0;
  always @(posedge clk) took <= req_valid;

  always @(negedge clk) begin
    exp_t x;
    if (took && q.size() > 0) begin
      x = q.pop_front();
      total++;
      if (err !== x.e || rd_valid !== x.v || (x.v && rd_data !== x.d)) begin
        bad++;
        $display("FAIL %s: err=%b rv=%b data=%h expected err=%b rv=%b data=%h",
                 x.tag, err, rd_valid, rd_data, x.e, x.v, x.d);
      end
    end
  end

  task automatic issue(input [2:0] op, input [11:0] a, input [7:0] d, input bit last,
                       input bit ee, input bit ev, input [7:0] ed, input string tag);
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_data = d; req_last = last;
    q.push_back('{ee, ev, ed, tag});
    @(posedge clk);
    #1 req_valid = 0; req_last = 0;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic wait_idle();
    while (busy) begin @(posedge clk); #1; end
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 0 && err === 0 && rd_valid === 0, "R1 idle outputs", {busy, err, rd_valid}, 0);
    issue(3, 12'h000, 0, 0, 0, 1, 8'h80, "R1 prot page0");
    issue(3, 12'hFFF, 0, 0, 0, 1, 8'h80, "R1 prot page127");

    issue(1, 12'h123, 8'hA5, 0, 0, 0, 0, "R2 byte write");
    n = 0;
    while (busy) begin n++; @(posedge clk); #1; end
    chk(n == P, "R8 busy length", n, P);
    issue(0, 12'h123, 0, 0, 0, 1, 8'hA5, "R2 read back");

    issue(1, 12'h124, 8'h11, 0, 0, 0, 0, "R8 first write");
    issue(1, 12'h124, 8'h22, 0, 1, 0, 0, "R8 write while busy");
    issue(0, 12'h124, 0, 0, 1, 0, 0, "R8 read while busy");
    wait_idle();
    issue(0, 12'h124, 0, 0, 0, 1, 8'h11, "R8 unchanged");

    issue(1, 12'h0A2, 8'h55, 0, 0, 0, 0, "R3 pre page5");
    wait_idle();
    issue(1, 12'h0C0, 8'h77, 0, 0, 0, 0, "R3 pre page6");
    wait_idle();
    issue(2, 12'h0BE, 8'h30, 0, 0, 0, 0, "R3 beat0");
    issue(2, 12'hFFF, 8'h31, 0, 0, 0, 0, "R3 beat1");
    issue(2, 12'h000, 8'h32, 0, 0, 0, 0, "R3 beat2");
    issue(2, 12'h000, 8'h33, 1, 0, 0, 0, "R3 commit");
    wait_idle();
    issue(0, 12'h0BE, 0, 0, 0, 1, 8'h30, "R3 ofs30");
    issue(0, 12'h0BF, 0, 0, 0, 1, 8'h31, "R3 ofs31");
    issue(0, 12'h0A0, 0, 0, 0, 1, 8'h32, "R3 wrap ofs0");
    issue(0, 12'h0A1, 0, 0, 0, 1, 8'h33, "R3 wrap ofs1");
    issue(0, 12'h0A2, 0, 0, 0, 1, 8'h55, "R3 unloaded kept");
    issue(0, 12'h0C0, 0, 0, 0, 1, 8'h77, "R3 next page kept");

    issue(2, 12'h0E3, 8'h41, 0, 0, 0, 0, "R9 beat0");
    issue(0, 12'h0E3, 0, 0, 1, 0, 0, "R9 read during load");
    issue(2, 12'h000, 8'h42, 1, 0, 0, 0, "R9 commit");
    wait_idle();
    issue(0, 12'h0E3, 0, 0, 0, 1, 8'h41, "R9 ofs3");
    issue(0, 12'h0E4, 0, 0, 0, 1, 8'h42, "R9 ofs4");

    issue(1, 12'h125, 8'h66, 0, 0, 0, 0, "R6 pre page9");
    wait_idle();
    issue(4, 12'h12F, 8'h7F, 0, 0, 0, 0, "R4 lock page9");
    wait_idle();
    issue(3, 12'h13F, 0, 0, 0, 1, 8'h00, "R4 prot page9 locked");
    issue(4, 12'h140, 8'h80, 0, 0, 0, 0, "R4 keep page10");
    wait_idle();
    issue(3, 12'h15A, 0, 0, 0, 1, 8'h80, "R4 prot page10");

    issue(1, 12'h125, 8'h99, 0, 1, 0, 0, "R6 byte to locked");
    issue(2, 12'h125, 8'hAB, 1, 1, 0, 0, "R6 commit to locked");
    chk(busy === 0, "R6 no busy", busy, 0);
    issue(0, 12'h125, 0, 0, 0, 1, 8'h66, "R6 unchanged");

    issue(4, 12'h120, 8'hFF, 0, 1, 0, 0, "R5 unlock attempt");
    issue(3, 12'h120, 0, 0, 0, 1, 8'h00, "R5 still locked");

    issue(1, 12'h200, 8'h01, 0, 0, 0, 0, "R7 pre write");
    wait_idle();
    low_supply = 1;
    issue(1, 12'h200, 8'hEE, 0, 1, 0, 0, "R7 byte low");
    issue(4, 12'h280, 8'h00, 0, 1, 0, 0, "R7 prot low");
    issue(2, 12'h200, 8'hEF, 1, 1, 0, 0, "R7 commit low");
    chk(busy === 0, "R7 no busy", busy, 0);
    issue(0, 12'h200, 0, 0, 0, 1, 8'h01, "R7 data kept");
    issue(3, 12'h280, 0, 0, 0, 1, 8'h80, "R7 prot kept");
    low_supply = 0;

    issue(5, 12'h000, 0, 0, 1, 0, 0, "R10 op5");
    issue(7, 12'h000, 0, 0, 1, 0, 0, "R10 op7");

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R2 scoreboard drained", q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule